// File: doc/BRIEF.md
# Complementary PWM Channel with Dead Time and Conversion Triggers

This block is one pulse-width channel that drives a high-side and a low-side output which never conduct together unless software forces them to. A free-running counter sets the period. The period length comes either from a shared value on an input port or from the channel's own period register. A duty compare defines the high-side interval. A four-state machine inserts a dead gap before each output turns on. The gap before the high side and the gap before the low side are programmed separately. Two compare registers each produce a single-cycle pulse at a chosen count. These pulses are meant to start an analog-to-digital conversion or to raise an interrupt.

Software programs the channel through a simple write port. The addresses are: 0 control, 1 duty, 2 own period, 3 high-side dead time, 4 low-side dead time, 5 conversion compare, 6 event compare. Address 7 is unused. Control writes act on the next cycle. All other registers are shadowed and reach the counter logic only at a period wrap.

The dead-time state machine has four states and these transitions:
- ST_LO_ON to ST_GAP_HI when the nominal high-side signal rises and dead time is enabled.
- ST_LO_ON to ST_HI_ON when it rises and dead time is disabled.
- ST_GAP_HI to ST_HI_ON when the gap counter runs out.
- ST_GAP_HI back to ST_LO_ON if the nominal signal falls during the gap.
- ST_HI_ON to ST_GAP_LO or straight to ST_LO_ON on the falling nominal signal, by the same rule.
- ST_GAP_LO to ST_LO_ON when its counter runs out.
- ST_GAP_LO back to ST_HI_ON if the nominal signal rises again during the gap.

Top module: `pwm_pair_gen`

## Requirements
- R1: Control bit 2 selects the period: 1 uses the period register, 0 uses `master_period`. The selected value P is sampled at each wrap, the counter runs 0..P-1, and one period lasts P cycles.
- R2: Let D be the duty value, Gh the high-side gap and Gl the low-side gap. In each period, starting at the high-side rising edge, `pwm_hi` is on for D-Gh cycles, both outputs are off for Gl cycles, `pwm_lo` is on for P-D-Gl cycles, and both are off for the last Gh cycles.
- R3: Control bits [1:0] give the dead-time mode. Values 00 and 11 enable gaps. Values 01 and 10 make Gh = Gl = 0, so the outputs switch directly.
- R4: When gaps are enabled, Gh comes from the register at address 3 and Gl from the register at address 4, independently. Units are clock cycles.
- R5: When gaps are enabled, a dead-time value below 16 is used as 16.
- R6: Duty, period, dead-time and compare writes take effect only at the next counter wrap. The period in progress keeps the old values.
- R7: Each trigger is a one-cycle pulse, one cycle after the counter equals its compare value C. Measured from the high-side rising edge, it appears at offset (C-Gh) mod P. Address 5 drives `adc_trig` and address 6 drives `evt_trig`.
- R8: A trigger fires only when 8 <= C < P. Any other value produces no pulse.
- R9: Control bit 3 (high) and bit 4 (low) are override enables. Each one alone forces its own pin to control bit 5 (high) or bit 6 (low), and the other pin keeps running normally.
- R10: Control bit 7 (high) and bit 8 (low) are pin enables. When one of these is 0, its pin follows control bit 9 (high) or bit 10 (low), whatever the override setting.
- R11: After reset the control word is zero, both pins are low and neither trigger pulses.
- R12: A write with `wr_en` high stores `wr_data` into the register at `wr_addr`, using the address map in the description above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| master_period | input | W | Shared period value |
| pwm_hi | output | 1 | High-side drive |
| pwm_lo | output | 1 | Low-side drive |
| adc_trig | output | 1 | Conversion trigger pulse |
| evt_trig | output | 1 | Event trigger pulse |

## Verification
The bench uses the default parameters: W of 16, a dead-time floor of 16 and a trigger floor of 8. Periods of 60 to 120 cycles are used, so a whole period can be captured and compared cycle by cycle. These settings make it possible to reach the clamp from both sides, the trigger floor, compare values equal to and just below the period, and a compare that is valid only under the master period. Random duty, gap and compare values are drawn so that each gap fits inside its on-interval.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    typedef enum logic [1:0] {
        ST_LO_ON  = 2'd0,
        ST_GAP_HI = 2'd1,
        ST_HI_ON  = 2'd2,
        ST_GAP_LO = 2'd3
    } db_state_t;

    typedef struct packed {
        logic       gpio_lo;
        logic       gpio_hi;
        logic       pen_lo;
        logic       pen_hi;
        logic       ovd_lo;
        logic       ovd_hi;
        logic       ove_lo;
        logic       ove_hi;
        logic       per_sel;
        logic [1:0] dt_mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int N_TRIG = 2;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_DUTY = 3'd1;
    localparam logic [2:0] A_PER  = 3'd2;
    localparam logic [2:0] A_DTHI = 3'd3;
    localparam logic [2:0] A_DTLO = 3'd4;
    localparam logic [2:0] A_TCMP = 3'd5;
    localparam logic [2:0] A_ECMP = 3'd6;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pair_pkg::*;
#(
    parameter int W  = 16,
    parameter int NT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         master_per,
    input  logic [W-1:0]         indiv_per,
    input  logic                 per_sel,
    input  logic [W-1:0]         duty_sh,
    input  logic [W-1:0]         dthi_sh,
    input  logic [W-1:0]         dtlo_sh,
    input  logic [NT-1:0][W-1:0] cmp_sh,
    output logic [W-1:0]         cnt,
    output logic [W-1:0]         per_act,
    output logic [W-1:0]         duty_act,
    output logic [W-1:0]         dthi_act,
    output logic [W-1:0]         dtlo_act,
    output logic [NT-1:0][W-1:0] cmp_act,
    output logic                 wrap
);

    logic [W-1:0] last;

    // Periods of 0 or 1 give a counter that stays at zero.
    assign last = (per_act <= W'(1)) ? '0 : per_act - W'(1);
    assign wrap = (cnt >= last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            per_act  <= '0;
            duty_act <= '0;
            dthi_act <= '0;
            dtlo_act <= '0;
            cmp_act  <= '0;
        end else if (wrap) begin
            cnt      <= '0;
            per_act  <= per_sel ? indiv_per : master_per;
            duty_act <= duty_sh;
            dthi_act <= dthi_sh;
            dtlo_act <= dtlo_sh;
            cmp_act  <= cmp_sh;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the count never reaches the active period.
    a_r1_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        (per_act > W'(1)) |-> (cnt < per_act));

    // R6: shadowed values stay put away from a wrap.
    a_r6_duty_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_act));

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
    import pwm_pair_pkg::*;
#(
    parameter int W      = 16,
    parameter int DT_MIN = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         raw,
    input  logic         dt_en,
    input  logic [W-1:0] dthi,
    input  logic [W-1:0] dtlo,
    output logic         hi_on,
    output logic         lo_on
);

    localparam logic [W-1:0] MIN_V = W'(DT_MIN);

    db_state_t    st, st_nx;
    logic [W-1:0] dcnt, dcnt_nx;
    logic [W-1:0] hi_ld, lo_ld;

    // Floor applied where the gap counter is loaded.
    assign hi_ld = ((dthi < MIN_V) ? MIN_V : dthi) - W'(1);
    assign lo_ld = ((dtlo < MIN_V) ? MIN_V : dtlo) - W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_LO_ON;
            dcnt <= '0;
        end else begin
            st   <= st_nx;
            dcnt <= dcnt_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        dcnt_nx = dcnt;
        unique case (st)
            ST_LO_ON: begin
                if (raw) begin
                    if (dt_en) begin
                        st_nx   = ST_GAP_HI;
                        dcnt_nx = hi_ld;
                    end else begin
                        st_nx = ST_HI_ON;
                    end
                end
            end
            ST_GAP_HI: begin
                if (!raw)             st_nx = ST_LO_ON;
                else if (dcnt == '0)  st_nx = ST_HI_ON;
                else                  dcnt_nx = dcnt - 1'b1;
            end
            ST_HI_ON: begin
                if (!raw) begin
                    if (dt_en) begin
                        st_nx   = ST_GAP_LO;
                        dcnt_nx = lo_ld;
                    end else begin
                        st_nx = ST_LO_ON;
                    end
                end
            end
            ST_GAP_LO: begin
                if (raw)              st_nx = ST_HI_ON;
                else if (dcnt == '0)  st_nx = ST_LO_ON;
                else                  dcnt_nx = dcnt - 1'b1;
            end
            default: st_nx = ST_LO_ON;
        endcase
    end

    always_comb begin
        hi_on = (st == ST_HI_ON);
        lo_on = (st == ST_LO_ON);
    end

    // R4: with gaps enabled the high side never turns on straight out of low-on.
    a_r4_gap_before_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_on) && $past(dt_en)) |-> $past(!lo_on));

    // R5: a freshly entered gap is never shorter than the floor.
    a_r5_hi_gap_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP_HI && $past(st) != ST_GAP_HI) |-> (dcnt >= MIN_V - W'(1)));
    a_r5_lo_gap_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP_LO && $past(st) != ST_GAP_LO) |-> (dcnt >= MIN_V - W'(1)));

endmodule

// File: rtl/pwm_trig_cmp.sv
module pwm_trig_cmp #(
    parameter int W        = 16,
    parameter int TRIG_MIN = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] per,
    output logic         pulse
);

    logic hit;

    assign hit = (cnt == cmp) && (cmp >= W'(TRIG_MIN)) && (cmp < per);

    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= hit;
    end

    // R7: every pulse lasts one cycle.
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R8: a pulse only follows an in-range compare value.
    a_r8_range_ok: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> ($past(cmp) >= W'(TRIG_MIN) && $past(cmp) < $past(per)));

endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen
    import pwm_pair_pkg::*;
#(
    parameter int W        = 16,
    parameter int DT_MIN   = 16,
    parameter int TRIG_MIN = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] master_period,
    output logic         pwm_hi,
    output logic         pwm_lo,
    output logic         adc_trig,
    output logic         evt_trig
);

    ctrl_t                   ctrl;
    logic [W-1:0]            duty_sh, per_sh, dthi_sh, dtlo_sh;
    logic [N_TRIG-1:0][W-1:0] cmp_sh;

    logic [W-1:0]            cnt, per_act, duty_act, dthi_act, dtlo_act;
    logic [N_TRIG-1:0][W-1:0] cmp_act;
    logic                    wrap;
    logic                    raw, dt_en, hi_on, lo_on;
    logic [N_TRIG-1:0]       trig_v;

    // Register write port (R12).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            duty_sh <= '0;
            per_sh  <= '0;
            dthi_sh <= '0;
            dtlo_sh <= '0;
            cmp_sh  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
                A_DUTY: duty_sh   <= wr_data;
                A_PER:  per_sh    <= wr_data;
                A_DTHI: dthi_sh   <= wr_data;
                A_DTLO: dtlo_sh   <= wr_data;
                A_TCMP: cmp_sh[0] <= wr_data;
                A_ECMP: cmp_sh[1] <= wr_data;
                default: ;
            endcase
        end
    end

    pwm_timebase #(.W(W), .NT(N_TRIG)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_per(master_period),
        .indiv_per (per_sh),
        .per_sel   (ctrl.per_sel),
        .duty_sh   (duty_sh),
        .dthi_sh   (dthi_sh),
        .dtlo_sh   (dtlo_sh),
        .cmp_sh    (cmp_sh),
        .cnt       (cnt),
        .per_act   (per_act),
        .duty_act  (duty_act),
        .dthi_act  (dthi_act),
        .dtlo_act  (dtlo_act),
        .cmp_act   (cmp_act),
        .wrap      (wrap)
    );

    assign raw   = (cnt < duty_act);
    assign dt_en = (ctrl.dt_mode == 2'b00) || (ctrl.dt_mode == 2'b11);

    pwm_deadband #(.W(W), .DT_MIN(DT_MIN)) u_db (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw),
        .dt_en(dt_en),
        .dthi (dthi_act),
        .dtlo (dtlo_act),
        .hi_on(hi_on),
        .lo_on(lo_on)
    );

    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
        pwm_trig_cmp #(.W(W), .TRIG_MIN(TRIG_MIN)) u_cmp (
            .clk  (clk),
            .rst_n(rst_n),
            .cnt  (cnt),
            .cmp  (cmp_act[g]),
            .per  (per_act),
            .pulse(trig_v[g])
        );
    end

    assign adc_trig = trig_v[0];
    assign evt_trig = trig_v[1];

    // Pin priority: GPIO hand-off, then override, then dead-time output.
    always_comb begin
        if (!ctrl.pen_hi)     pwm_hi = ctrl.gpio_hi;
        else if (ctrl.ove_hi) pwm_hi = ctrl.ovd_hi;
        else                  pwm_hi = hi_on;

        if (!ctrl.pen_lo)     pwm_lo = ctrl.gpio_lo;
        else if (ctrl.ove_lo) pwm_lo = ctrl.ovd_lo;
        else                  pwm_lo = lo_on;
    end

endmodule

// File: tb/sim_pwm_pair_gen.sv
module sim_pwm_pair_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] master_period;
    logic        pwm_hi, pwm_lo, adc_trig, evt_trig;

    always #4 clk = ~clk;

    pwm_pair_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .master_period(master_period),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .adc_trig(adc_trig), .evt_trig(evt_trig)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic hs [0:255];
    logic ls [0:255];
    logic ts [0:255];
    logic es [0:255];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gap(input int mode, input int dt);
        if (mode == 0 || mode == 3) return (dt < 16) ? 16 : dt;
        return 0;
    endfunction

    function automatic logic [15:0] mk_ctrl(input int mode, input bit sel, input bit oveh, input bit ovel,
                                            input bit ovdh, input bit ovdl, input bit penh, input bit penl,
                                            input bit gh, input bit gl);
        logic [1:0] m;
        m = mode[1:0];
        return {5'b0, gl, gh, penl, penh, ovdl, ovdh, ovel, oveh, sel, m};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input int mode, input bit sel, input int per, input int duty,
                       input int dth, input int dtl, input int tc, input int ec);
        wr(3'd0, mk_ctrl(mode, sel, 0, 0, 0, 0, 1, 1, 0, 0));
        wr(3'd1, 16'(duty));
        wr(3'd2, 16'(per));
        wr(3'd3, 16'(dth));
        wr(3'd4, 16'(dtl));
        wr(3'd5, 16'(tc));
        wr(3'd6, 16'(ec));
        repeat (300) @(negedge clk);
    endtask

    task automatic capture(input int per, input bit align, input bit do_wr,
                           input logic [2:0] a, input logic [15:0] d);
        int guard;
        logic prev;
        guard = 0;
        @(negedge clk);
        if (align) begin
            prev = pwm_hi;
            @(negedge clk);
            while (!(prev == 1'b0 && pwm_hi == 1'b1) && guard < 5000) begin
                prev = pwm_hi;
                @(negedge clk);
                guard++;
            end
            if (guard >= 5000) chk(0, "R2", "high-side edge seen", 0, 1);
        end
        for (int i = 0; i < per; i++) begin
            if (i > 0) @(negedge clk);
            hs[i] = pwm_hi; ls[i] = pwm_lo; ts[i] = adc_trig; es[i] = evt_trig;
            if (do_wr && i == 0) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
            if (i == 1) wr_en = 1'b0;
        end
        wr_en = 1'b0;
    endtask

    task automatic check_pat(input string req, input int per, input int duty, input int dh, input int dl);
        int bad, hc;
        bit eh, el;
        bad = 0; hc = 0;
        for (int i = 0; i < per; i++) begin
            eh = (i < duty - dh);
            el = (i >= duty - dh + dl) && (i < per - dh);
            if (hs[i] !== eh || ls[i] !== el) bad++;
            if (hs[i] === 1'b1) hc++;
        end
        chk(bad == 0, req, "cycles off the expected pattern", bad, 0);
        chk(hc == duty - dh, req, "high-side on cycles", hc, duty - dh);
    endtask

    task automatic check_trg(input string req, input bit which, input int per, input int cmp, input int dh);
        int cnt, pos, epos;
        bit valid;
        cnt = 0; pos = -1;
        for (int i = 0; i < per; i++) begin
            if ((which ? es[i] : ts[i]) === 1'b1) begin cnt++; pos = i; end
        end
        valid = (cmp >= 8) && (cmp < per);
        chk(cnt == (valid ? 1 : 0), req, which ? "event pulses per period" : "conversion pulses per period",
            cnt, valid ? 1 : 0);
        if (valid) begin
            epos = ((cmp - dh) % per + per) % per;
            chk(pos == epos, req, "trigger offset from high edge", pos, epos);
        end
    endtask

    task automatic count_free(input string req, input int per, input int exp_h, input int exp_l);
        int hc, lc;
        hc = 0; lc = 0;
        capture(per, 0, 0, 3'd0, 16'd0);
        for (int i = 0; i < per; i++) begin
            if (hs[i] === 1'b1) hc++;
            if (ls[i] === 1'b1) lc++;
        end
        chk(hc == exp_h, req, "high pin on cycles", hc, exp_h);
        chk(lc == exp_l, req, "low pin on cycles", lc, exp_l);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog: actual 0 expected 1 (run completed)");
            summary();
            $finish;
        end
    end

    initial begin
        int mode, per, duty, dth, dtl, tc, ec;
        bit sel;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; master_period = 16'd100;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        begin
            int act;
            act = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                act += int'(pwm_hi) + int'(pwm_lo) + int'(adc_trig) + int'(evt_trig);
            end
            chk(act == 0, "R11", "active output cycles after reset", act, 0);
        end

        // Gaps disabled by mode 10, own period.
        cfg(2, 1, 80, 30, 20, 20, 10, 50);
        capture(80, 1, 0, 3'd0, 16'd0);
        check_pat("R3", 80, 30, 0, 0);
        check_trg("R7", 0, 80, 10, 0);
        check_trg("R12", 1, 80, 50, 0);

        // Separate gaps, mode 00.
        cfg(0, 1, 80, 30, 20, 24, 30, 8);
        capture(80, 1, 0, 3'd0, 16'd0);
        check_pat("R4", 80, 30, 20, 24);
        check_trg("R7", 0, 80, 30, 20);
        check_trg("R8", 1, 80, 8, 20);

        // Clamp, mode 11; out-of-range compares.
        cfg(3, 1, 80, 30, 3, 0, 7, 80);
        capture(80, 1, 0, 3'd0, 16'd0);
        check_pat("R5", 80, 30, 16, 16);
        check_trg("R8", 0, 80, 7, 16);
        check_trg("R8", 1, 80, 80, 16);

        // Mode 01 disables gaps; compare at period-1.
        cfg(1, 1, 80, 30, 20, 20, 79, 0);
        capture(80, 1, 0, 3'd0, 16'd0);
        check_pat("R3", 80, 30, 0, 0);
        check_trg("R8", 0, 80, 79, 0);
        check_trg("R8", 1, 80, 0, 0);

        // Master period selected.
        master_period = 16'd100;
        cfg(2, 0, 80, 30, 0, 0, 90, 85);
        capture(100, 1, 0, 3'd0, 16'd0);
        check_pat("R1", 100, 30, 0, 0);
        check_trg("R1", 0, 100, 90, 0);

        // Double buffering of duty.
        cfg(2, 1, 80, 30, 0, 0, 0, 0);
        capture(80, 1, 1, 3'd1, 16'd50);
        check_pat("R6", 80, 30, 0, 0);
        capture(80, 1, 0, 3'd0, 16'd0);
        check_pat("R6", 80, 50, 0, 0);

        // Per-pin override.
        wr(3'd1, 16'd30);
        repeat (200) @(negedge clk);
        wr(3'd0, mk_ctrl(2, 1, 1, 0, 1, 0, 1, 1, 0, 0));
        count_free("R9", 80, 80, 50);
        wr(3'd0, mk_ctrl(2, 1, 0, 1, 0, 1, 1, 1, 0, 0));
        count_free("R9", 80, 30, 80);

        // GPIO hand-off wins over override.
        wr(3'd0, mk_ctrl(2, 1, 1, 1, 0, 1, 0, 0, 1, 0));
        count_free("R10", 80, 80, 0);
        wr(3'd0, mk_ctrl(2, 1, 1, 0, 1, 0, 0, 1, 0, 0));
        count_free("R10", 80, 0, 50);

        // Constrained random configurations.
        void'($urandom(32'd7));
        for (int k = 0; k < 12; k++) begin
            mode = int'($urandom % 4);
            sel  = 1'($urandom % 2);
            per  = 60 + int'($urandom % 60);
            duty = 30 + int'($urandom % (per - 59));
            dth  = int'($urandom % 25);
            dtl  = int'($urandom % 25);
            tc   = int'($urandom % (per + 6));
            ec   = int'($urandom % (per + 6));
            master_period = 16'(per);
            cfg(mode, sel, sel ? per : per + 7, duty, dth, dtl, tc, ec);
            capture(per, 1, 0, 3'd0, 16'd0);
            check_pat("R2", per, duty, gap(mode, dth), gap(mode, dtl));
            check_trg("R8", 0, per, tc, gap(mode, dth));
            check_trg("R7", 1, per, ec, gap(mode, dth));
        end

        done = 1;
        summary();
        $finish;
    end

endmodule